// File: doc/BRIEF.md
# Triggered One-Shot Delay Timer

This block turns one short trigger pulse into one long timed window. A trigger may come from another clock domain and may last only one clock period. It passes through an optional synchronizer chain and a rising-edge detector. The first detected edge opens the window: the window output goes high and a counter starts. When the counter has covered the programmed number of cycles, the window closes and a one-cycle done strobe marks the end. With the default of 2,000,000 cycles at a 10 MHz clock, the window lasts 200 ms.

Nothing in the block acts as a clock. Downstream logic should treat the window level and the done strobe as ordinary enables in the same clock domain. A build-time switch sets what a fresh edge does while the window is open. It either restarts the count, which extends the window, or it has no effect.

Top module: `oneshot_window_timer`

## Requirements
- R1: A synchronous active-high reset clears the window, the done strobe, the counter, the synchronizer stages and the edge history. While reset is high and after it is released with the trigger low, both outputs stay low.
- R2: Only a rising edge of the trigger starts a window. A trigger one cycle wide starts exactly one window. A trigger held high for longer than the window also starts exactly one window.
- R3: With SYNC_STAGES = 2, the window output goes high after the third rising clock edge, counting from the first edge that samples the trigger high. With SYNC_STAGES = 0, it goes high after that first edge.
- R4: If no edge arrives during the window, the window output stays high for exactly TICKS clock cycles.
- R5: The counter holds zero while the window is low. It counts up by one on every cycle while the window is high and never exceeds TICKS-1.
- R6: After a window closes, done_o is high for exactly one cycle. That cycle is the first cycle in which window_o is low again.
- R7: With RETRIGGER = 0, an edge that arrives while the window is open has no effect. This holds even for an edge in the window's last cycle: the window still lasts TICKS cycles and no second window follows.
- R8: With RETRIGGER = 1, an edge while the window is open resets the count to zero. The window then ends TICKS cycles after that edge, so its total length is the number of cycles already elapsed plus TICKS. An edge in the last cycle keeps the window open and gives no done strobe at that point.
- R9: A reset during an open window closes it at once, with no done strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger, possibly asynchronous, possibly one cycle wide |
| window_o | output | 1 | High for the duration of the timed window |
| done_o | output | 1 | One-cycle strobe on the first cycle after the window ends |

## Verification
The hardest case to reach is a new edge that lands exactly on the window's terminal cycle, where restart and close compete. The synchronizer delay shifts that cycle by two clocks relative to the raw trigger. The stimulus runs two instances side by side, one with the synchronizer and without restart, the other without the synchronizer and with restart. It places a second single-cycle pulse at precomputed offsets, so that each instance sees an edge in its last cycle or one cycle before it. The window length, the position of the done strobe and the number of windows opened tell which side won.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DELAY = 1'b1
  } win_state_e;

  // Counter width needed to hold 0 .. ticks-1.
  function automatic int unsigned count_width(input int unsigned ticks);
    return (ticks > 1) ? $clog2(ticks) : 1;
  endfunction

  // Window length seen at the output when a restart lands `elapsed` cycles
  // after the window opened.
  function automatic int unsigned restarted_len(input int unsigned elapsed,
                                                input int unsigned ticks);
    return elapsed + ticks;
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);

  generate
    if (SYNC_STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] stg_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          stg_q <= '0;
        end else begin
          stg_q[0] <= d_i;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            stg_q[i] <= stg_q[i-1];
          end
        end
      end
      assign q_o = stg_q[SYNC_STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b0;
    else       prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R2
  rise_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o);

endmodule

// File: rtl/window_ctrl.sv
module window_ctrl
  import oneshot_pkg::*;
#(
  parameter int unsigned TICKS     = 2_000_000,
  parameter bit          RETRIGGER = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic rise_i,
  output logic window_o,
  output logic done_o
);

  localparam int unsigned CW = count_width(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  win_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  // Named internal events
  logic in_delay, term_hit, start_evt, reload_evt, end_evt;

  always_comb begin
    in_delay   = (st_q == ST_DELAY);
    term_hit   = in_delay && (cnt_q == LAST);
    start_evt  = rise_i && !in_delay;
    reload_evt = RETRIGGER && rise_i && in_delay;
    end_evt    = term_hit && !reload_evt;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= end_evt;
      if (start_evt || reload_evt) begin
        st_q  <= ST_DELAY;
        cnt_q <= '0;
      end else if (end_evt) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
      end else if (in_delay) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign window_o = in_delay;
  assign done_o   = done_q;

  // R1
  reset_clears_chk: assert property (@(posedge clk_i)
    rst_i |=> (st_q == ST_IDLE && cnt_q == '0 && !done_q));

  // R5
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_delay |-> cnt_q == '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    in_delay |-> cnt_q <= LAST);

  // R2
  idle_rise_opens_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_i && !in_delay) |=> (in_delay && cnt_q == '0));

  // R6
  done_after_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_q |-> (!in_delay && $past(in_delay)));

  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_q |=> !done_q);

  generate
    if (RETRIGGER) begin : g_retrig_chk
      // R8
      retrig_reload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_i && in_delay) |=> (in_delay && cnt_q == '0 && !done_q));
    end else begin : g_ignore_chk
      // R7
      ignore_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_i && in_delay && cnt_q != LAST) |=>
          (in_delay && cnt_q == $past(cnt_q) + 1'b1));
    end
  endgenerate

endmodule

// File: rtl/oneshot_window_timer.sv
module oneshot_window_timer #(
  parameter int unsigned TICKS       = 2_000_000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          RETRIGGER   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic trig_i,
  output logic window_o,
  output logic done_o
);

  logic trig_sync_w;
  logic trig_rise_w;

  trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (trig_i),
    .q_o   (trig_sync_w)
  );

  rise_detect u_rise (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .lvl_i  (trig_sync_w),
    .rise_o (trig_rise_w)
  );

  window_ctrl #(.TICKS(TICKS), .RETRIGGER(RETRIGGER)) u_ctrl (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .rise_i   (trig_rise_w),
    .window_o (window_o),
    .done_o   (done_o)
  );

  // R9
  reset_no_done_chk: assert property (@(posedge clk_i)
    rst_i |=> (!window_o && !done_o));

endmodule

// File: tb/tb_oneshot_window_timer.sv
module tb_oneshot_window_timer;

  localparam int unsigned T        = 20;
  localparam int          CASE_CYC = 70;
  localparam int          N_VEC    = 6;
  localparam int          LAT_A    = 3;   // SYNC_STAGES=2
  localparam int          LAT_B    = 1;   // SYNC_STAGES=0

  // width, second-pulse cycle (0 = none), expected len A (no restart), len B (restart)
  localparam int VEC [N_VEC][4] = '{
    '{ 1,  0, 20, 20},
    '{ 4,  0, 20, 20},
    '{30,  0, 20, 20},
    '{ 1, 10, 20, 30},
    '{ 2, 19, 20, 39},
    '{ 1, 20, 20, 40}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic win_a, done_a, win_b, done_b;
  int   checks = 0;
  int   fails  = 0;

  always #5 clk = ~clk;

  oneshot_window_timer #(.TICKS(T), .SYNC_STAGES(2), .RETRIGGER(1'b0)) dut (
    .clk_i(clk), .rst_i(rst), .trig_i(trig), .window_o(win_a), .done_o(done_a));

  oneshot_window_timer #(.TICKS(T), .SYNC_STAGES(0), .RETRIGGER(1'b1)) dut_rt (
    .clk_i(clk), .rst_i(rst), .trig_i(trig), .window_o(win_b), .done_o(done_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int w, input int s, input int la, input int lb);
    int hi_a = 0, hi_b = 0, first_a = -1, first_b = -1, last_a = -1, last_b = -1;
    int rise_a = 0, rise_b = 0, dn_a = 0, dn_b = 0, dpos_a = -1, dpos_b = -1;
    logic p_a = 1'b0, p_b = 1'b0;
    for (int c = 0; c < CASE_CYC; c++) begin
      @(negedge clk);
      if (win_a) begin hi_a++; last_a = c; if (first_a < 0) first_a = c; if (!p_a) rise_a++; end
      if (win_b) begin hi_b++; last_b = c; if (first_b < 0) first_b = c; if (!p_b) rise_b++; end
      p_a = win_a;
      p_b = win_b;
      if (done_a) begin dn_a++; dpos_a = c; end
      if (done_b) begin dn_b++; dpos_b = c; end
      trig = (c < w) || (s != 0 && c == s);
    end
    chk(first_a == LAT_A, "R3 latency with synchronizer", first_a, LAT_A);
    chk(first_b == LAT_B, "R3 latency without synchronizer", first_b, LAT_B);
    chk(rise_a == 1, "R2 windows opened (A)", rise_a, 1);
    chk(rise_b == 1, "R2 windows opened (B)", rise_b, 1);
    chk(hi_a == la, "R4/R7 window length (A)", hi_a, la);
    chk(hi_b == lb, "R4/R8 window length (B)", hi_b, lb);
    chk(dn_a == 1 && dpos_a == last_a + 1, "R6 done position (A)", dpos_a, last_a + 1);
    chk(dn_b == 1 && dpos_b == last_b + 1, "R6 done position (B)", dpos_b, last_b + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    chk(!win_a && !done_a && !win_b && !done_b, "R1 outputs during reset",
        {win_a, done_a, win_b, done_b}, 0);
    rst = 1'b0;
    seen = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      seen += win_a + done_a + win_b + done_b;
    end
    chk(seen == 0, "R1 quiet after reset release", seen, 0);

    for (int v = 0; v < N_VEC; v++) begin
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
    end

    // R9: reset in the middle of an open window
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (6) @(negedge clk);
    chk(win_a && win_b, "R9 window open before reset", {win_a, win_b}, 3);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!win_a && !win_b && !done_a && !done_b, "R9 closed by reset",
        {win_a, done_a, win_b, done_b}, 0);
    seen = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      seen += win_a + done_a + win_b + done_b;
    end
    chk(seen == 0, "R9 no done strobe after reset", seen, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule